// File: doc/BRIEF.md
# Compare-Based Timer Counter Channel

A single up-counting timer channel for a microcontroller-style peripheral. The count advances on a tick picked by a clock-select field: the system clock prescaled by 2, 8, 32 or 128, a pulse stream from a slow clock domain that has already been brought into this clock domain, or a chained pulse from a neighbouring channel. Two compare registers, RA and RC, are checked on each tick. RC can leave the counter free-running, return it to zero to give a periodic timer, or stop its clock to give a one-shot timer.

Software reaches the channel through a simple synchronous write/read port. Mode, RA and RC are plain registers. The command, interrupt-enable and interrupt-disable registers act only on the bits written as one. A status register returns the compare flags and the clock-enable state, and reading it clears the flags. One waveform output is set on an RA compare and cleared on an RC compare. One interrupt line combines the flags with their mask bits.

Top module: `tmr_channel`

## Requirements
- R1: After synchronous reset the following all read zero: the count (address 8), the status (address 7), the interrupt mask (address 6), wave_out and irq.
- R2: Bits [2:0] of the mode register (address 0) select the count tick. Codes 0, 1, 2 and 3 give the system clock divided by 2, 8, 32 and 128. Code 4 selects slow_tick pulses, code 5 selects ext_tick pulses, and codes 6 and 7 give no tick. Pulses on a source that is not selected leave the count unchanged.
- R3: While mode bit 3 is zero and the clock is enabled, the count rises by one per tick and wraps from 2^CNT_W-1 to 0. A match with RC (address 2) does not reset it.
- R4: While mode bit 3 is one, a tick that arrives while the count equals RC returns the count to zero. The period is therefore RC+1 ticks.
- R5: While mode bit 4 is one, an RC compare event clears the counter clock enable and the count holds at RC. This takes precedence over mode bit 3.
- R6: An RC compare event is a tick while the clock is enabled and the count equals RC. It sets status bit 0. An RA compare event (the same, with RA at address 1) sets status bit 1. irq is high while a flag is set and its mask bit is set (mask bit 0 for RC, bit 1 for RA).
- R7: Writing address 4 sets every mask bit that is one in the data. Writing address 5 clears every such bit. Writing 0xFF to address 5 masks every source.
- R8: A write to address 3 acts on the bits written as one. Bit 0 enables the counter clock, bit 1 disables it, and bit 2 resets the count to zero. When bits 0 and 1 are written together the clock ends disabled. Ticks while the clock is disabled leave the count unchanged.
- R9: Status bit 16 reads one exactly while the counter clock is enabled.
- R10: If mode bit 5 is set, an RA compare event drives wave_out high. If mode bit 6 is set, an RC compare event drives it low. When both happen on the same tick, low wins.
- R11: A read of address 7 returns the flags and then clears both. An event in the same cycle as the read leaves its flag set.
- R12: A new RC value written while the counter runs is used from the next tick on, and the count is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_tick | input | 1 | One-cycle pulses from the slow time base |
| ext_tick | input | 1 | One-cycle pulses from a chained source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en |
| wave_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt request, level |

## Verification
A wrong count or compare decision shows within one tick: the count read back drifts from the period the bench predicts, or the RC flag and irq appear one tick early or late. A clock-enable state that does not match the expected value shows in status bit 16 as soon as that bit is read, and also as a count that keeps moving or stays frozen over the next few ticks. A fault in the mask or flag logic shows on irq as soon as the flags and mask are written or read. A fault in the prescaler shows as a wrong number of cycles between successive interrupts in periodic mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // number of system-clock prescaler taps (divide by 2, 8, 32, 128)
    localparam int NDIV  = 4;
    localparam int PRE_W = 2 * (NDIV - 1) + 1;

    // interrupt sources
    localparam int NSRC   = 2;
    localparam int SRC_RC = 0;
    localparam int SRC_RA = 1;

    // command bits
    localparam int CMD_EN_BIT  = 0;
    localparam int CMD_DIS_BIT = 1;
    localparam int CMD_TRG_BIT = 2;

    // status layout
    localparam int ST_CLKEN_BIT = 16;

    typedef enum logic [3:0] {
        A_MODE = 4'd0,
        A_RA   = 4'd1,
        A_RC   = 4'd2,
        A_CMD  = 4'd3,
        A_IEN  = 4'd4,
        A_IDIS = 4'd5,
        A_MASK = 4'd6,
        A_STAT = 4'd7,
        A_CNT  = 4'd8
    } addr_e;

    typedef enum logic [2:0] {
        CS_DIV2   = 3'd0,
        CS_DIV8   = 3'd1,
        CS_DIV32  = 3'd2,
        CS_DIV128 = 3'd3,
        CS_SLOW   = 3'd4,
        CS_EXT    = 3'd5,
        CS_OFF6   = 3'd6,
        CS_OFF7   = 3'd7
    } clksel_e;

    typedef struct packed {
        logic    clr_on_rc;
        logic    set_on_ra;
        logic    stop_on_rc;
        logic    autoreset;
        clksel_e clksel;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    function automatic logic sel_is_div(input clksel_e s);
        return (s == CS_DIV2) || (s == CS_DIV8) || (s == CS_DIV32) || (s == CS_DIV128);
    endfunction

endpackage

// File: rtl/tmr_presc.sv
module tmr_presc
    import tmr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  clksel_e sel,
    input  logic    slow_tick,
    input  logic    ext_tick,
    output logic    tick
);

    logic [PRE_W-1:0] pre;
    logic [NDIV-1:0]  div_tick;

    always_ff @(posedge clk) begin
        if (rst) pre <= '0;
        else     pre <= pre + PRE_W'(1);
    end

    // tap i fires once every 2^(2i+1) cycles
    for (genvar i = 0; i < NDIV; i++) begin : g_div
        assign div_tick[i] = &pre[2*i:0];
    end

    always_comb begin
        tick = 1'b0;
        if (sel_is_div(sel))      tick = div_tick[sel[1:0]];
        else if (sel == CS_SLOW)  tick = slow_tick;
        else if (sel == CS_EXT)   tick = ext_tick;
    end

    // R2: unused codes never produce a tick
    p_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
        ((sel == CS_OFF6) || (sel == CS_OFF7)) |-> !tick);

    // R2: divide-by-2 never ticks on two cycles in a row
    p_div2_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (sel == CS_DIV2 && $past(sel) == CS_DIV2 && $past(tick)) |-> !tick);

endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  mode_t            mode,
    input  logic [CNT_W-1:0] ra,
    input  logic [CNT_W-1:0] rc,
    input  logic             cmd_en,
    input  logic             cmd_dis,
    input  logic             cmd_trg,
    output logic [CNT_W-1:0] cnt,
    output logic             clken,
    output logic             rc_evt,
    output logic             ra_evt,
    output logic             wave
);

    logic step;

    assign step   = tick && clken;
    assign rc_evt = step && (cnt == rc);
    assign ra_evt = step && (cnt == ra);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cmd_trg) begin
            cnt <= '0;
        end else if (rc_evt && mode.stop_on_rc) begin
            cnt <= cnt;
        end else if (rc_evt && mode.autoreset) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                             clken <= 1'b0;
        else if (cmd_dis)                    clken <= 1'b0;
        else if (cmd_en)                     clken <= 1'b1;
        else if (rc_evt && mode.stop_on_rc)  clken <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                              wave <= 1'b0;
        else if (rc_evt && mode.clr_on_rc)    wave <= 1'b0;
        else if (ra_evt && mode.set_on_ra)    wave <= 1'b1;
    end

    // R8: software trigger zeroes the count
    p_trg_zero_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_trg |=> (cnt == '0));

    // R8: disable wins over enable
    p_dis_wins_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_dis |=> !clken);

    // R4: auto-reset returns to zero after an RC match
    p_autoreset_r4: assert property (@(posedge clk) disable iff (rst)
        (rc_evt && mode.autoreset && !mode.stop_on_rc && !cmd_trg) |=> (cnt == '0));

    // R5: one-shot stops the clock and holds the count
    p_oneshot_r5: assert property (@(posedge clk) disable iff (rst)
        (rc_evt && mode.stop_on_rc && !cmd_trg && !cmd_en) |=> (!clken && cnt == $past(cnt)));

    // R3: a disabled counter does not move without a trigger
    p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (!clken && !cmd_trg) |=> $stable(cnt));

    // R10: RC clear dominates the waveform
    p_wave_clr_r10: assert property (@(posedge clk) disable iff (rst)
        (rc_evt && mode.clr_on_rc) |=> !wave);

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              clken,
    input  logic              rc_evt,
    input  logic              ra_evt,
    output mode_t             mode,
    output logic [CNT_W-1:0]  ra,
    output logic [CNT_W-1:0]  rc,
    output logic              cmd_en,
    output logic              cmd_dis,
    output logic              cmd_trg,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] events;
    logic            wr_cmd;
    logic            wr_ien;
    logic            wr_idis;
    logic            rd_stat;

    assign wr_cmd  = wr_en && (addr == A_CMD);
    assign wr_ien  = wr_en && (addr == A_IEN);
    assign wr_idis = wr_en && (addr == A_IDIS);
    assign rd_stat = rd_en && (addr == A_STAT);

    assign cmd_en  = wr_cmd && wdata[CMD_EN_BIT];
    assign cmd_dis = wr_cmd && wdata[CMD_DIS_BIT];
    assign cmd_trg = wr_cmd && wdata[CMD_TRG_BIT];

    always_comb begin
        events         = '0;
        events[SRC_RC] = rc_evt;
        events[SRC_RA] = ra_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
            ra   <= '0;
            rc   <= '0;
        end else if (wr_en) begin
            case (addr)
                A_MODE:  mode <= mode_t'(wdata[MODE_W-1:0]);
                A_RA:    ra   <= wdata[CNT_W-1:0];
                A_RC:    rc   <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          mask <= '0;
        else if (wr_ien)  mask <= mask | wdata[NSRC-1:0];
        else if (wr_idis) mask <= mask & ~wdata[NSRC-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~{NSRC{rd_stat}}) | events;
    end

    assign irq = |(flags & mask);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_MODE: rdata = DATA_W'(mode);
                A_RA:   rdata = DATA_W'(ra);
                A_RC:   rdata = DATA_W'(rc);
                A_MASK: rdata = DATA_W'(mask);
                A_STAT: begin
                    rdata[NSRC-1:0]     = flags;
                    rdata[ST_CLKEN_BIT] = clken;
                end
                A_CNT:  rdata = DATA_W'(cnt);
                default: rdata = '0;
            endcase
        end
    end

    // R6: an RC event always leaves its flag set
    p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
        rc_evt |=> flags[SRC_RC]);

    // R11: a quiet status read leaves no flag
    p_read_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !rc_evt && !ra_evt) |=> (flags == '0));

    // R7: disabling all sources empties the mask
    p_idis_all_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_idis && wdata[7:0] == 8'hFF) |=> (mask == '0));

    // R6: no interrupt without a pending flag
    p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic              ext_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wave_out,
    output logic              irq
);

    mode_t            mode;
    logic [CNT_W-1:0] ra;
    logic [CNT_W-1:0] rc;
    logic [CNT_W-1:0] cnt;
    logic             cmd_en;
    logic             cmd_dis;
    logic             cmd_trg;
    logic             clken;
    logic             rc_evt;
    logic             ra_evt;
    logic             tick;

    tmr_presc u_presc (
        .clk       (clk),
        .rst       (rst),
        .sel       (mode.clksel),
        .slow_tick (slow_tick),
        .ext_tick  (ext_tick),
        .tick      (tick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode    (mode),
        .ra      (ra),
        .rc      (rc),
        .cmd_en  (cmd_en),
        .cmd_dis (cmd_dis),
        .cmd_trg (cmd_trg),
        .cnt     (cnt),
        .clken   (clken),
        .rc_evt  (rc_evt),
        .ra_evt  (ra_evt),
        .wave    (wave_out)
    );

    tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .cnt     (cnt),
        .clken   (clken),
        .rc_evt  (rc_evt),
        .ra_evt  (ra_evt),
        .mode    (mode),
        .ra      (ra),
        .rc      (rc),
        .cmd_en  (cmd_en),
        .cmd_dis (cmd_dis),
        .cmd_trg (cmd_trg),
        .rdata   (rdata),
        .irq     (irq)
    );

endmodule

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;

    localparam int W = 16;
    localparam int unsigned MAXV = (1 << W) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wave_out;
    logic        irq;

    tmr_channel #(.CNT_W(W), .DATA_W(32)) i_tmr_channel (
        .clk(clk), .rst(rst), .slow_tick(slow_tick), .ext_tick(ext_tick),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wave_out(wave_out), .irq(irq)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // reference model state
    int unsigned m_cnt = 0, m_ra = 0, m_rc = 0;
    bit m_clken = 0, m_frc = 0, m_fra = 0, m_wave = 0;
    bit [1:0] m_mask = 0;
    bit [2:0] m_sel = 0;
    bit m_auto = 0, m_stop = 0, m_set = 0, m_clr = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        return (32'(m_clken) << 16) | (32'(m_fra) << 1) | 32'(m_frc);
    endfunction

    function automatic logic exp_irq();
        return (m_frc & m_mask[0]) | (m_fra & m_mask[1]);
    endfunction

    task automatic mstep(input bit is_slow);
        bit rc_e, ra_e;
        if (!m_clken) return;
        if (is_slow ? (m_sel != 3'd4) : (m_sel != 3'd5)) return;
        rc_e = (m_cnt == m_rc);
        ra_e = (m_cnt == m_ra);
        if (rc_e) m_frc = 1;
        if (ra_e) m_fra = 1;
        if (rc_e && m_clr) m_wave = 0;
        else if (ra_e && m_set) m_wave = 1;
        if (rc_e && m_stop) m_clken = 0;
        else if (rc_e && m_auto) m_cnt = 0;
        else m_cnt = (m_cnt + 1) & MAXV;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
        case (a)
            4'd0: begin m_sel = d[2:0]; m_auto = d[3]; m_stop = d[4]; m_set = d[5]; m_clr = d[6]; end
            4'd1: m_ra = d & MAXV;
            4'd2: m_rc = d & MAXV;
            4'd3: begin
                if (d[2]) m_cnt = 0;
                if (d[1]) m_clken = 0;
                else if (d[0]) m_clken = 1;
            end
            4'd4: m_mask = m_mask | d[1:0];
            4'd5: m_mask = m_mask & ~d[1:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 0;
        if (a == 4'd7) begin m_frc = 0; m_fra = 0; end
    endtask

    task automatic tk(input int n, input bit slow);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (slow) slow_tick = 1; else ext_tick = 1;
            @(posedge clk);
            mstep(slow);
        end
        @(negedge clk);
        slow_tick = 0; ext_tick = 0;
    endtask

    task automatic chk_cnt(input string req);
        logic [31:0] d;
        rd(4'd8, d);
        chk(req, d, m_cnt);
    endtask

    task automatic chk_stat(input string req);
        logic [31:0] d;
        logic [31:0] e;
        e = exp_stat();
        rd(4'd7, d);
        chk(req, d, e);
    endtask

    task automatic chk_pins(input string req);
        #1;
        chk({req, " irq"}, irq, exp_irq());
        chk({req, " wave"}, wave_out, m_wave);
    endtask

    task automatic period(output int p);
        logic [31:0] d;
        int t1;
        rd(4'd7, d);
        while (!irq) @(negedge clk);
        t1 = cyc;
        rd(4'd7, d);
        while (!irq) @(negedge clk);
        p = cyc - t1;
    endtask

    task automatic resync();
        logic [31:0] d;
        wr(4'd0, 32'd5);
        wr(4'd3, 32'h5);
        rd(4'd7, d);
        wr(4'd5, 32'hFF);
    endtask

    bit done = 0;

    initial begin
        #1900000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int p;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        chk_cnt("R1 count");
        rd(4'd7, d); chk("R1 status", d, 32'h0);
        rd(4'd6, d); chk("R1 mask", d, 32'h0);
        chk_pins("R1");

        // R8 / R9 command behaviour
        wr(4'd0, 32'd5);
        wr(4'd3, 32'h5);
        chk_stat("R9 clock enabled");
        tk(5, 0);
        chk_cnt("R3 counts ticks");
        wr(4'd3, 32'h3);
        chk_stat("R8 disable wins, R9 status");
        tk(3, 0);
        chk_cnt("R8 no count while disabled");
        wr(4'd3, 32'h1);
        wr(4'd3, 32'h4);
        chk_cnt("R8 trigger zeroes count");

        // R3 up mode ignores RC, R6 flag and mask, R7
        wr(4'd2, 32'd3);
        tk(6, 0);
        chk_cnt("R3 passes RC");
        chk_pins("R6 masked flag");
        wr(4'd4, 32'h1);
        chk_pins("R6 irq after enable");
        wr(4'd5, 32'hFF);
        chk_pins("R7 all masked");
        rd(4'd6, d); chk("R7 mask read", d, 32'h0);
        chk_stat("R11 status before clear");
        chk_stat("R11 status after clear");

        // R4 auto-reset period
        wr(4'd0, 32'h0D);
        wr(4'd2, 32'd4);
        wr(4'd3, 32'h4);
        tk(4, 0);
        chk_cnt("R4 reaches RC");
        tk(1, 0);
        chk_cnt("R4 back to zero");
        tk(5, 0);
        chk_cnt("R4 period RC+1");
        chk_stat("R4 flags");

        // R11 event in the same cycle as the status read
        tk(4, 0);
        chk_cnt("R11 setup at RC");
        @(negedge clk);
        rd_en = 1; addr = 4'd7; ext_tick = 1;
        #1 d = rdata;
        @(posedge clk);
        m_frc = 0; m_fra = 0;
        mstep(0);
        @(negedge clk);
        rd_en = 0; ext_tick = 0;
        chk_stat("R11 event survives read");

        // R12 RC rewrite while running
        wr(4'd2, 32'd20);
        wr(4'd3, 32'h4);
        tk(8, 0);
        wr(4'd2, 32'd10);
        chk_cnt("R12 no restart on RC write");
        tk(3, 0);
        chk_cnt("R12 new RC used");

        // R5 one-shot
        wr(4'd0, 32'h1D);
        wr(4'd2, 32'd6);
        wr(4'd3, 32'h5);
        tk(10, 0);
        chk_cnt("R5 holds at RC");
        chk_stat("R5 clock stopped");

        // R10 waveform
        wr(4'd0, 32'h6D);
        wr(4'd1, 32'd2);
        wr(4'd2, 32'd5);
        wr(4'd3, 32'h5);
        tk(3, 0);
        chk_pins("R10 set on RA");
        tk(3, 0);
        chk_pins("R10 clear on RC");
        wr(4'd3, 32'h4);
        tk(3, 0);
        wr(4'd1, 32'd5);
        tk(3, 0);
        chk_pins("R10 clear wins");
        chk_cnt("R10 count");
        rd(4'd7, d);

        // R2 slow source, external ignored
        wr(4'd0, 32'd4);
        wr(4'd1, 32'd0);
        wr(4'd2, 32'd100);
        wr(4'd3, 32'h5);
        tk(7, 1);
        tk(3, 0);
        chk_cnt("R2 slow source only");

        // R2 codes 6 and 7 give no tick
        wr(4'd0, 32'd6);
        wr(4'd3, 32'h4);
        repeat (200) @(negedge clk);
        chk_cnt("R2 code 6 idle");
        wr(4'd0, 32'd7);
        repeat (200) @(negedge clk);
        chk_cnt("R2 code 7 idle");

        // R2 prescaler periods
        wr(4'd2, 32'd4);
        wr(4'd4, 32'h1);
        wr(4'd0, 32'h09);
        wr(4'd3, 32'h5);
        period(p); chk("R2 divide by 8 period", p, 40);
        wr(4'd0, 32'h08);
        period(p); chk("R2 divide by 2 period", p, 10);
        wr(4'd2, 32'd2);
        wr(4'd0, 32'h0A);
        period(p); chk("R2 divide by 32 period", p, 96);
        resync();

        // R3 wrap at full scale
        wr(4'd2, 32'd100);
        wr(4'd3, 32'h5);
        tk(65540, 0);
        chk_cnt("R3 wrap");
        rd(4'd7, d);

        // random mix
        for (int it = 0; it < 150; it++) begin
            logic [31:0] md;
            md = 32'd5;
            md[3] = $urandom_range(0, 1);
            md[4] = ($urandom_range(0, 3) == 0);
            md[5] = $urandom_range(0, 1);
            md[6] = $urandom_range(0, 1);
            wr(4'd0, md);
            wr(4'd1, $urandom_range(0, 31));
            wr(4'd2, $urandom_range(2, 31));
            if ($urandom_range(0, 1)) wr(4'd4, $urandom_range(0, 3));
            else wr(4'd5, $urandom_range(0, 3));
            wr(4'd3, $urandom_range(0, 3) == 0 ? 32'h1 : 32'h5);
            tk($urandom_range(1, 40), 0);
            chk_cnt("R4 random count");
            chk_pins("R6 random");
            chk_stat("R6 random status");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule